// File: doc/BRIEF.md
# Fault Exception Priority Escalator

This block collects pending requests for the six system-level exceptions of a processor core: reset, non-maskable interrupt, hard fault, memory-management fault, bus fault and usage fault. Every cycle it picks the single exception that should be taken next. Reset, NMI and hard fault sit at fixed levels above everything else. The three configurable faults each carry a programmable 3-bit priority and an enable bit.

A configurable fault that is disabled, or whose priority does not beat the current execution priority, is not dropped. It is folded into a hard-fault activation instead. When the hard fault is taken, the pending bits of the escalated faults clear together with it.

The block also keeps a sticky stacking-error flag. The flag is set when a bus error response comes back on a write that was a stack push, and software clears it by writing one. The winning vector number and a one-cycle activate strobe leave the block as registered outputs.

Top module: `fault_escalator`

## Requirements
- R1: Vector numbers are fixed: reset=1, NMI=2, hard fault=3, memory-management=4, bus fault=5, usage fault=6. Bit i of `pending` belongs to vector i+1, and `act_vec` carries the vector number.
- R2: Fixed ranks order the non-configurable exceptions: reset (rank 0) beats NMI (rank 1), NMI beats hard fault (rank 2), and all three beat any configurable fault.
- R3: A configurable fault with priority p has rank 3+p. The lower rank wins, and between equal ranks the lower vector number wins.
- R4: A pending configurable fault whose enable bit is 0 escalates. Hard fault (vector 3) is activated in its place, and the escalated fault's pending bit clears on the same edge as the hard fault's.
- R5: A pending, enabled configurable fault whose rank is not below `exec_rank` escalates to hard fault in the same way as in R4.
- R6: An activation happens only when the winner's rank is strictly below `exec_rank` (0 to 10 in rank form, 11 to 15 meaning no active handler). Otherwise no strobe is produced and every pending bit is held.
- R7: NMI is pended by either `nmi_pin` or `nmi_sw` and has no enable bit.
- R8: A request sampled at one clock edge shows in `pending` after that edge. `act_valid` is a one-cycle pulse that rises one edge later, and the winner's pending bit clears on that same edge.
- R9: `bus_err_wr` pends the bus fault. When `stack_push` is also high in that cycle, `stk_err` is set.
- R10: `stk_err` holds until `stk_clr` is high for a cycle. A new stacking error in the same cycle as a clear leaves it set.
- R11: After reset, `pending`, `act_valid`, `act_vec` and `stk_err` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rst_req | input | 1 | Pends the reset exception |
| nmi_pin | input | 1 | External NMI request |
| nmi_sw | input | 1 | Software NMI pend request |
| hf_req | input | 1 | Direct hard-fault request |
| mm_req | input | 1 | Memory-management fault request |
| uf_req | input | 1 | Usage fault request |
| bus_err_wr | input | 1 | Bus error response, pends bus fault |
| stack_push | input | 1 | Qualifies the bus error as a stack push |
| mm_en | input | 1 | Memory-management fault enable |
| bf_en | input | 1 | Bus fault enable |
| uf_en | input | 1 | Usage fault enable |
| mm_pri | input | 3 | Memory-management fault priority |
| bf_pri | input | 3 | Bus fault priority |
| uf_pri | input | 3 | Usage fault priority |
| exec_rank | input | 4 | Current execution priority in rank form |
| stk_clr | input | 1 | Write-one clear of the stacking-error flag |
| act_valid | output | 1 | One-cycle activate strobe |
| act_vec | output | 3 | Vector number being activated |
| pending | output | 6 | Pending bits, bit i = vector i+1 |
| stk_err | output | 1 | Sticky stacking-error flag |

## Verification
The main sweep pends every subset of the three configurable faults under every combination of enable bits. It repeats this for four priority sets, including all-equal ties and inverted orderings, and for execution ranks from 2 up to 15. The sweep separates normal arbitration, ties resolved by vector number, escalation caused by a disable and escalation caused by too low a priority. At an execution rank of 2, even the hard fault is blocked, so the bench can see that pending bits are held. Directed patterns stack reset, NMI and hard fault together to show the fixed order and the back-to-back strobes. A blocked NMI is later released by raising the execution rank. The stacking flag is tested with a plain bus error, with a stack-push bus error, with a clear, and with a set and clear in the same cycle.

// File: rtl/fe_pkg.sv
package fe_pkg;
    localparam int NUM_EXC   = 6;
    localparam int NUM_CFG   = 3;
    localparam int FIX_LVLS  = 3;
    localparam int VEC_W     = 3;
    localparam int IDX_W     = $clog2(NUM_EXC);

    localparam int IDX_RST   = 0;
    localparam int IDX_NMI   = 1;
    localparam int IDX_HF    = 2;
    localparam int IDX_CFG0  = 3;

    typedef struct packed {
        logic [NUM_EXC-1:0] pend;
        logic               act;
        logic [VEC_W-1:0]   vec;
        logic               stk;
    } fe_state_t;
endpackage

// File: rtl/fe_rank_map.sv
module fe_rank_map #(
    parameter int N      = 3,
    parameter int PRI_W  = 3,
    parameter int RANK_W = 4,
    parameter int BASE   = 3
) (
    input  logic [N-1:0]        pend,
    input  logic [N-1:0]        en,
    input  logic [N*PRI_W-1:0]  pri,
    input  logic [RANK_W-1:0]   exec_rank,
    output logic [N-1:0]        elig,
    output logic [N-1:0]        esc,
    output logic [N*RANK_W-1:0] rank
);
    for (genvar g = 0; g < N; g++) begin : g_src
        logic [RANK_W-1:0] r;
        assign r = {{(RANK_W-PRI_W){1'b0}}, pri[g*PRI_W +: PRI_W]} + RANK_W'(BASE);
        assign rank[g*RANK_W +: RANK_W] = r;
        assign elig[g] = pend[g] & en[g] & (r < exec_rank);
        assign esc[g]  = pend[g] & ~(en[g] & (r < exec_rank));
    end
endmodule

// File: rtl/fe_arbiter.sv
module fe_arbiter #(
    parameter int N      = 6,
    parameter int RANK_W = 4,
    localparam int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]        cand_valid,
    input  logic [N*RANK_W-1:0] cand_rank,
    output logic                win_valid,
    output logic [IDX_W-1:0]    win_idx,
    output logic [RANK_W-1:0]   win_rank
);
    always_comb begin
        win_valid = 1'b0;
        win_idx   = '0;
        win_rank  = '1;
        for (int i = 0; i < N; i++) begin
            if (cand_valid[i] &&
                (!win_valid || (cand_rank[i*RANK_W +: RANK_W] < win_rank))) begin
                win_valid = 1'b1;
                win_idx   = IDX_W'(i);
                win_rank  = cand_rank[i*RANK_W +: RANK_W];
            end
        end
    end
endmodule

// File: rtl/fault_escalator.sv
module fault_escalator
    import fe_pkg::*;
#(
    parameter int PRI_W  = 3,
    localparam int RANK_W = $clog2(FIX_LVLS + (1 << PRI_W) + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rst_req,
    input  logic              nmi_pin,
    input  logic              nmi_sw,
    input  logic              hf_req,
    input  logic              mm_req,
    input  logic              uf_req,
    input  logic              bus_err_wr,
    input  logic              stack_push,
    input  logic              mm_en,
    input  logic              bf_en,
    input  logic              uf_en,
    input  logic [PRI_W-1:0]  mm_pri,
    input  logic [PRI_W-1:0]  bf_pri,
    input  logic [PRI_W-1:0]  uf_pri,
    input  logic [RANK_W-1:0] exec_rank,
    input  logic              stk_clr,
    output logic              act_valid,
    output logic [VEC_W-1:0]  act_vec,
    output logic [NUM_EXC-1:0] pending,
    output logic              stk_err
);
    fe_state_t st_q, st_d;

    logic [NUM_CFG-1:0]        cfg_elig, cfg_esc;
    logic [NUM_CFG*RANK_W-1:0] cfg_rank;
    logic [NUM_EXC-1:0]        cand_valid;
    logic [NUM_EXC*RANK_W-1:0] cand_rank;
    logic                      win_valid;
    logic [IDX_W-1:0]          win_idx;
    logic [RANK_W-1:0]         win_rank;
    logic                      go;
    logic [NUM_EXC-1:0]        set_m, clr_m;

    fe_rank_map #(
        .N(NUM_CFG), .PRI_W(PRI_W), .RANK_W(RANK_W), .BASE(FIX_LVLS)
    ) u_rank_map (
        .pend      (st_q.pend[NUM_EXC-1:IDX_CFG0]),
        .en        ({uf_en, bf_en, mm_en}),
        .pri       ({uf_pri, bf_pri, mm_pri}),
        .exec_rank (exec_rank),
        .elig      (cfg_elig),
        .esc       (cfg_esc),
        .rank      (cfg_rank)
    );

    always_comb begin
        cand_valid = {cfg_elig, st_q.pend[IDX_HF] | (|cfg_esc),
                      st_q.pend[IDX_NMI], st_q.pend[IDX_RST]};
        cand_rank  = {cfg_rank, RANK_W'(IDX_HF), RANK_W'(IDX_NMI), RANK_W'(IDX_RST)};
    end

    fe_arbiter #(.N(NUM_EXC), .RANK_W(RANK_W)) u_arb (
        .cand_valid (cand_valid),
        .cand_rank  (cand_rank),
        .win_valid  (win_valid),
        .win_idx    (win_idx),
        .win_rank   (win_rank)
    );

    always_comb begin
        go    = win_valid && (win_rank < exec_rank);
        set_m = {uf_req, bus_err_wr, mm_req, hf_req, nmi_pin | nmi_sw, rst_req};
        clr_m = '0;
        if (go) begin
            clr_m[win_idx] = 1'b1;
            if (win_idx == IDX_W'(IDX_HF)) begin
                clr_m[NUM_EXC-1:IDX_CFG0] = cfg_esc;
            end
        end

        st_d      = st_q;
        st_d.pend = (st_q.pend & ~clr_m) | set_m;
        st_d.act  = go;
        st_d.vec  = go ? VEC_W'(win_idx) + VEC_W'(1) : '0;
        st_d.stk  = (st_q.stk & ~stk_clr) | (bus_err_wr & stack_push);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign act_valid = st_q.act;
    assign act_vec   = st_q.vec;
    assign pending   = st_q.pend;
    assign stk_err   = st_q.stk;
endmodule

// File: rtl/fe_checker.sv
module fe_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       nmi_pin,
    input logic       nmi_sw,
    input logic       bus_err_wr,
    input logic       stack_push,
    input logic       stk_clr,
    input logic [3:0] exec_rank,
    input logic       act_valid,
    input logic [2:0] act_vec,
    input logic [5:0] pending,
    input logic       stk_err
);
    logic [5:0] pend_prev;
    always_ff @(posedge clk) pend_prev <= pending;

    // R1: a strobe always carries one of the six vectors
    a_r1_vec_range: assert property (@(posedge clk) disable iff (!rst_n)
        act_valid |-> (act_vec >= 3'd1 && act_vec <= 3'd6));

    // R6: nothing can beat execution rank 0
    a_r6_rank_zero_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_rank == 4'd0) |=> !act_valid);

    // R7: either NMI source pends vector 2
    a_r7_nmi_pends: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_pin || nmi_sw) |=> pending[1]);

    // R8: a non-escalated activation comes from a pending bit
    a_r8_act_from_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (act_valid && act_vec != 3'd3) |-> pend_prev[3'(act_vec - 3'd1)]);

    // R9: bus error pends bus fault; with stack push it sets the flag
    a_r9_bus_pends: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err_wr |=> pending[4]);
    a_r9_stk_set: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_err_wr && stack_push) |=> stk_err);

    // R10: sticky until cleared, clear works without a new error
    a_r10_stk_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (stk_err && !stk_clr) |=> stk_err);
    a_r10_stk_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (stk_clr && !(bus_err_wr && stack_push)) |=> !stk_err);
endmodule

bind fault_escalator fe_checker u_fe_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .nmi_pin    (nmi_pin),
    .nmi_sw     (nmi_sw),
    .bus_err_wr (bus_err_wr),
    .stack_push (stack_push),
    .stk_clr    (stk_clr),
    .exec_rank  (exec_rank),
    .act_valid  (act_valid),
    .act_vec    (act_vec),
    .pending    (pending),
    .stk_err    (stk_err)
);

// File: tb/fault_escalator_bench.sv
`timescale 1ns/1ps
module fault_escalator_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rst_req = 0, nmi_pin = 0, nmi_sw = 0, hf_req = 0, mm_req = 0, uf_req = 0;
    logic       bus_err_wr = 0, stack_push = 0, stk_clr = 0;
    logic       mm_en = 0, bf_en = 0, uf_en = 0;
    logic [2:0] mm_pri = 0, bf_pri = 0, uf_pri = 0;
    logic [3:0] exec_rank = 4'd15;
    logic       act_valid;
    logic [2:0] act_vec;
    logic [5:0] pending;
    logic       stk_err;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #4 clk = ~clk;

    fault_escalator u_fault_escalator (
        .clk(clk), .rst_n(rst_n), .rst_req(rst_req), .nmi_pin(nmi_pin), .nmi_sw(nmi_sw),
        .hf_req(hf_req), .mm_req(mm_req), .uf_req(uf_req), .bus_err_wr(bus_err_wr),
        .stack_push(stack_push), .mm_en(mm_en), .bf_en(bf_en), .uf_en(uf_en),
        .mm_pri(mm_pri), .bf_pri(bf_pri), .uf_pri(uf_pri), .exec_rank(exec_rank),
        .stk_clr(stk_clr), .act_valid(act_valid), .act_vec(act_vec),
        .pending(pending), .stk_err(stk_err)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // m: bit0 rst, bit1 nmi_pin, bit2 hf, bit3 mm, bit4 bus error, bit5 uf
    // Returns at the negedge after the activation edge.
    task automatic pulse(input logic [5:0] m, input logic sp, input logic sw);
        @(negedge clk);
        rst_req = m[0]; nmi_pin = m[1]; hf_req = m[2];
        mm_req = m[3]; bus_err_wr = m[4]; uf_req = m[5];
        stack_push = sp; nmi_sw = sw;
        @(negedge clk);
        {rst_req, nmi_pin, hf_req, mm_req, bus_err_wr, uf_req, stack_push, nmi_sw} = '0;
        @(negedge clk);
    endtask

    function automatic logic [8:0] pri_set(input int s);
        case (s)
            0: pri_set = {3'd0, 3'd0, 3'd0};
            1: pri_set = {3'd7, 3'd2, 3'd5};
            2: pri_set = {3'd1, 3'd3, 3'd3};
            default: pri_set = {3'd0, 3'd6, 3'd7};
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int ex_list[6] = '{2, 4, 6, 8, 11, 15};
        do_reset();
        @(negedge clk);
        // R11 reset state
        chk("R11 pending", pending, 0);
        chk("R11 act_valid", act_valid, 0);
        chk("R11 act_vec", act_vec, 0);
        chk("R11 stk_err", stk_err, 0);

        // R2 / R8: reset, NMI and hard fault pended together
        exec_rank = 4'd15;
        pulse(6'b000111, 1'b0, 1'b0);
        chk("R2 first vec", act_vec, 1);
        chk("R8 first strobe", act_valid, 1);
        chk("R8 pending after first", pending, 6'b000110);
        @(negedge clk);
        chk("R2 second vec", act_vec, 2);
        @(negedge clk);
        chk("R2 third vec", act_vec, 3);
        @(negedge clk);
        chk("R8 strobe drops", act_valid, 0);
        chk("R8 drained", pending, 0);

        // R7: software NMI wins at exec rank 2
        exec_rank = 4'd2;
        pulse(6'b000000, 1'b0, 1'b1);
        chk("R7 sw nmi strobe", act_valid, 1);
        chk("R7 sw nmi vec", act_vec, 2);
        // R6: pin NMI blocked at rank 1, then released
        exec_rank = 4'd1;
        pulse(6'b000010, 1'b0, 1'b0);
        chk("R6 blocked strobe", act_valid, 0);
        chk("R6 blocked pending", pending, 6'b000010);
        exec_rank = 4'd15;
        @(negedge clk);
        chk("R7 released vec", act_vec, 2);
        chk("R7 released strobe", act_valid, 1);

        // R6: exec rank 0 blocks even reset
        exec_rank = 4'd0;
        pulse(6'b000001, 1'b0, 1'b0);
        chk("R6 rank0 strobe", act_valid, 0);
        // R1: pending bit positions
        pulse(6'b001000, 1'b0, 1'b0);
        chk("R1 mm bit", pending, 6'b001001);
        pulse(6'b100000, 1'b0, 1'b0);
        chk("R1 uf bit", pending, 6'b101001);
        do_reset();

        // R9 / R10: stacking flag
        exec_rank = 4'd15; bf_en = 1; bf_pri = 3'd1;
        pulse(6'b010000, 1'b0, 1'b0);
        chk("R9 bus vec", act_vec, 5);
        chk("R9 plain error no flag", stk_err, 0);
        pulse(6'b010000, 1'b1, 1'b0);
        chk("R9 push vec", act_vec, 5);
        chk("R9 push flag", stk_err, 1);
        repeat (5) @(negedge clk);
        chk("R10 flag held", stk_err, 1);
        stk_clr = 1; @(negedge clk); stk_clr = 0;
        chk("R10 flag cleared", stk_err, 0);
        pulse(6'b010000, 1'b1, 1'b0);
        stk_clr = 1; bus_err_wr = 1; stack_push = 1;
        @(negedge clk);
        stk_clr = 0; bus_err_wr = 0; stack_push = 0;
        chk("R10 set beats clear", stk_err, 1);

        // R3 / R4 / R5 / R6 sweep over configurable faults
        for (int pm = 0; pm < 8; pm++) begin
            for (int en = 0; en < 8; en++) begin
                for (int ps = 0; ps < 4; ps++) begin
                    for (int ei = 0; ei < 6; ei++) begin
                        logic [8:0] pv;
                        int pr[3];
                        int ex, best_r, best_v, escm, exp_pend;
                        bit go;
                        pv = pri_set(ps);
                        pr[0] = pv[2:0]; pr[1] = pv[5:3]; pr[2] = pv[8:6];
                        ex = ex_list[ei];
                        do_reset();
                        mm_en = en[0]; bf_en = en[1]; uf_en = en[2];
                        mm_pri = pv[2:0]; bf_pri = pv[5:3]; uf_pri = pv[8:6];
                        exec_rank = 4'(ex);
                        best_r = 99; best_v = 0; escm = 0;
                        for (int k = 0; k < 3; k++) begin
                            if (pm[k]) begin
                                if (en[k] && (3 + pr[k]) < ex) begin
                                    if ((3 + pr[k]) < best_r) begin
                                        best_r = 3 + pr[k];
                                        best_v = 4 + k;
                                    end
                                end else begin
                                    escm |= (1 << k);
                                end
                            end
                        end
                        if (escm != 0) begin
                            best_r = 2; best_v = 3;
                        end
                        go = (best_v != 0) && (best_r < ex);
                        exp_pend = pm << 3;
                        if (go) begin
                            if (best_v == 3) exp_pend &= ~(escm << 3);
                            else exp_pend &= ~(1 << (best_v - 1));
                        end
                        pulse({pm[2], pm[1], pm[0], 3'b000}, 1'b0, 1'b0);
                        chk("R6 sweep strobe", act_valid, go);
                        chk("R3/R4/R5 sweep vec", act_vec, go ? best_v : 0);
                        chk("R4/R8 sweep pending", pending, exp_pend);
                    end
                end
            end
        end

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule